// File: doc/BRIEF.md
# Ordered Store Buffer with Atomic Bypass

This block sits in the load/store unit of an in-order core, between the execute stage and the data cache. Ordinary stores and cache-maintenance operations are parked in a small circular queue and written to the cache oldest first, at most one per cycle. Every incoming load is looked up against the queued stores of its own thread, and the result comes out one cycle later. That result is one of three outcomes: the load is fully covered and gets its bytes, the load is partly covered and must wait for the queue to empty, or the load is not covered and must read the cache.

Requests that must not be buffered are strictly ordered stores, load-linked/store-conditional stores, swaps and atomic read-modify-write operations. These go past the queue through a single holding slot. Such a request goes to the cache only when no queued entry overlaps its byte range. It may overtake queued stores to other addresses. An atomic operation that straddles a cache line is refused with an error pulse and is never issued.

Top module: `stbuf_top`

## Requirements
- R1: Kinds STRICT (3), LLSC (4), SWAP (5) and AMO (6) never occupy a queue slot. Kinds STORE (1) and CMO (2) are queued. LOAD is kind 0.
- R2: A non-bufferable request whose byte range overlaps a queued entry stays off the cache port until that entry has been accepted by the cache. The cache therefore sees the store first.
- R3: A held non-bufferable request that overlaps no queued entry takes the cache port ahead of older queued stores.
- R4: An AMO request reaches the cache with an all-zero data field, whatever data it arrived with.
- R5: An AMO whose bytes `addr .. addr + 2^size - 1` span two LINE_BYTES-aligned lines is accepted, raises `amo_err` for one cycle in the next cycle, and is never issued. An in-line AMO raises no error.
- R6: The load lookup picks the youngest overlapping candidate entry. If that entry covers the load, `fwd_code` is FULL (1) and `fwd_data` holds the load's bytes, little-endian (byte at addr+i in bits 8i+7..8i), zero above the load size. The result appears the cycle after the load is accepted.
- R7: Only entries whose thread ID equals the load's are candidates.
- R8: CMO entries are never candidates.
- R9: If the chosen entry only partly covers the load, `fwd_code` is PARTIAL (2). If no candidate overlaps, it is NONE (0). In both cases `fwd_data` is zero.
- R10: The queue drains in arrival order, one entry per cycle while `c_ready` is high. It holds DEPTH entries, then raises `sb_full` and refuses further stores.
- R11: With the queue empty and nothing held, a non-bufferable request appears on the cache port in the same cycle it is presented.
- R12: After reset the queue is empty, the cache port is idle, and `fwd_valid` and `amo_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request presented |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_kind | input | 3 | Request kind code (see R1) |
| req_tid | input | TW | Thread ID |
| req_addr | input | AW | Byte address of first byte |
| req_size | input | SW | log2 of access bytes |
| req_data | input | DW | Store data, little-endian from req_addr |
| fwd_valid | output | 1 | Lookup result valid (one cycle per load) |
| fwd_code | output | 2 | NONE 0, FULL 1, PARTIAL 2 |
| fwd_data | output | DW | Forwarded load bytes |
| amo_err | output | 1 | Line-crossing atomic rejected |
| sb_empty | output | 1 | Queue holds no entry |
| sb_full | output | 1 | Queue holds DEPTH entries |
| c_valid | output | 1 | Cache request valid |
| c_ready | input | 1 | Cache accepts the request |
| c_kind | output | 3 | Kind of the cache request |
| c_tid | output | TW | Thread ID of the cache request |
| c_addr | output | AW | Address of the cache request |
| c_size | output | SW | Size code of the cache request |
| c_data | output | DW | Write data of the cache request |

## Verification
The range checks assume that no access wraps past the top of the address space and that the size code never exceeds log2 of the data bytes. The stimulus uses small addresses and sizes up to 3 only. The assertions also assume that the driver holds a request steady until it is taken, and that kind 7 is never sent. The directed tasks change request fields only while `req_valid` is low or once the request has been accepted. They throttle `c_ready` to hold entries in the queue while conflicts and lookups are exercised.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;

  typedef enum logic [2:0] {
    K_LOAD   = 3'd0,
    K_STORE  = 3'd1,
    K_CMO    = 3'd2,
    K_STRICT = 3'd3,
    K_LLSC   = 3'd4,
    K_SWAP   = 3'd5,
    K_AMO    = 3'd6
  } req_kind_e;

  typedef enum logic [1:0] {
    FWD_NONE = 2'd0,
    FWD_FULL = 2'd1,
    FWD_PART = 2'd2
  } fwd_code_e;

  function automatic logic kind_queued(req_kind_e k);
    return (k == K_STORE) || (k == K_CMO);
  endfunction

  function automatic logic kind_direct(req_kind_e k);
    return (k == K_STRICT) || (k == K_LLSC) || (k == K_SWAP) || (k == K_AMO);
  endfunction

endpackage

// File: rtl/stbuf_ring.sv
module stbuf_ring #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int TW    = 2,
  parameter int SW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [SW-1:0] push_size,
  input  logic [DW-1:0] push_data,
  input  logic [TW-1:0] push_tid,
  input  logic          push_cmo,
  input  logic          pop,
  output logic          full,
  output logic          empty,
  output logic          age_vld  [DEPTH],
  output logic [AW-1:0] age_addr [DEPTH],
  output logic [SW-1:0] age_size [DEPTH],
  output logic [DW-1:0] age_data [DEPTH],
  output logic [TW-1:0] age_tid  [DEPTH],
  output logic          age_cmo  [DEPTH]
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] mem_addr [DEPTH];
  logic [SW-1:0] mem_size [DEPTH];
  logic [DW-1:0] mem_data [DEPTH];
  logic [TW-1:0] mem_tid  [DEPTH];
  logic          mem_cmo  [DEPTH];

  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (push) begin
      mem_addr[wr_ptr] <= push_addr;
      mem_size[wr_ptr] <= push_size;
      mem_data[wr_ptr] <= push_data;
      mem_tid[wr_ptr]  <= push_tid;
      mem_cmo[wr_ptr]  <= push_cmo;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // age-ordered view: index 0 is the oldest entry
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    logic [PW:0]   sum;
    logic [PW-1:0] slot;
    assign sum  = {1'b0, rd_ptr} + (PW+1)'(k);
    assign slot = (sum >= (PW+1)'(DEPTH)) ? PW'(sum - (PW+1)'(DEPTH)) : sum[PW-1:0];
    assign age_vld[k]  = (CW'(k) < count);
    assign age_addr[k] = mem_addr[slot];
    assign age_size[k] = mem_size[slot];
    assign age_data[k] = mem_data[slot];
    assign age_tid[k]  = mem_tid[slot];
    assign age_cmo[k]  = mem_cmo[slot];
  end

  p_no_push_full_r10: assert property (@(posedge clk) disable iff (rst)
    push |-> !full) else $error("push into full queue");

  p_no_pop_empty_r10: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty) else $error("pop from empty queue");

endmodule

// File: rtl/stbuf_scan.sv
module stbuf_scan
  import stbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int TW    = 2,
  parameter int SW    = 2
) (
  input  logic          age_vld  [DEPTH],
  input  logic [AW-1:0] age_addr [DEPTH],
  input  logic [SW-1:0] age_size [DEPTH],
  input  logic [DW-1:0] age_data [DEPTH],
  input  logic [TW-1:0] age_tid  [DEPTH],
  input  logic          age_cmo  [DEPTH],
  input  logic [TW-1:0] ld_tid,
  input  logic [AW-1:0] ld_addr,
  input  logic [SW-1:0] ld_size,
  input  logic [AW-1:0] nb_addr,
  input  logic [SW-1:0] nb_size,
  output fwd_code_e     fwd_code,
  output logic [DW-1:0] fwd_data,
  output logic          nb_conflict
);
  localparam int OW = (DW > 8) ? $clog2(DW / 8) : 1;

  function automatic logic [AW-1:0] last_byte(logic [AW-1:0] a, logic [SW-1:0] s);
    return a + ({{(AW-1){1'b0}}, 1'b1} << s) - 1'b1;
  endfunction

  logic [AW-1:0] ld_hi, nb_hi;
  logic [DW-1:0] ld_mask;

  assign ld_hi   = last_byte(ld_addr, ld_size);
  assign nb_hi   = last_byte(nb_addr, nb_size);
  assign ld_mask = ~({DW{1'b1}} << (32'd8 << ld_size));

  // later (younger) hits overwrite earlier ones
  always_comb begin
    logic [AW-1:0] e_hi;
    logic [AW-1:0] off;
    fwd_code = FWD_NONE;
    fwd_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      e_hi = last_byte(age_addr[k], age_size[k]);
      off  = ld_addr - age_addr[k];
      if (age_vld[k] && !age_cmo[k] && (age_tid[k] == ld_tid) &&
          (age_addr[k] <= ld_hi) && (ld_addr <= e_hi)) begin
        if ((age_addr[k] <= ld_addr) && (ld_hi <= e_hi)) begin
          fwd_code = FWD_FULL;
          fwd_data = (age_data[k] >> {off[OW-1:0], 3'b000}) & ld_mask;
        end else begin
          fwd_code = FWD_PART;
          fwd_data = '0;
        end
      end
    end
  end

  always_comb begin
    logic [AW-1:0] e_hi;
    nb_conflict = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      e_hi = last_byte(age_addr[k], age_size[k]);
      if (age_vld[k] && (age_addr[k] <= nb_hi) && (nb_addr <= e_hi))
        nb_conflict = 1'b1;
    end
  end

endmodule

// File: rtl/stbuf_top.sv
module stbuf_top
  import stbuf_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int TW         = 2,
  parameter int LINE_BYTES = 64,
  parameter int SW         = $clog2($clog2(DW / 8) + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_kind,
  input  logic [TW-1:0] req_tid,
  input  logic [AW-1:0] req_addr,
  input  logic [SW-1:0] req_size,
  input  logic [DW-1:0] req_data,
  output logic          fwd_valid,
  output logic [1:0]    fwd_code,
  output logic [DW-1:0] fwd_data,
  output logic          amo_err,
  output logic          sb_empty,
  output logic          sb_full,
  output logic          c_valid,
  input  logic          c_ready,
  output logic [2:0]    c_kind,
  output logic [TW-1:0] c_tid,
  output logic [AW-1:0] c_addr,
  output logic [SW-1:0] c_size,
  output logic [DW-1:0] c_data
);
  localparam int LW = $clog2(LINE_BYTES);

  function automatic logic spans_lines(logic [AW-1:0] a, logic [SW-1:0] s);
    logic [AW-1:0] hi;
    hi = a + ({{(AW-1){1'b0}}, 1'b1} << s) - 1'b1;
    return a[AW-1:LW] != hi[AW-1:LW];
  endfunction

  req_kind_e kind;
  logic is_ld, is_q, is_nb, bad_amo, acc;
  logic push, pop;

  logic          pend_v;
  req_kind_e     pend_kind;
  logic [TW-1:0] pend_tid;
  logic [AW-1:0] pend_addr;
  logic [SW-1:0] pend_size;
  logic [DW-1:0] pend_data;

  logic          age_vld  [DEPTH];
  logic [AW-1:0] age_addr [DEPTH];
  logic [SW-1:0] age_size [DEPTH];
  logic [DW-1:0] age_data [DEPTH];
  logic [TW-1:0] age_tid  [DEPTH];
  logic          age_cmo  [DEPTH];

  fwd_code_e     scan_code;
  logic [DW-1:0] scan_data;
  logic          nb_conflict;
  logic          sel_pend, sel_byp, sel_head;
  logic [DW-1:0] req_wdata;

  assign kind    = req_kind_e'(req_kind);
  assign is_ld   = (kind == K_LOAD);
  assign is_q    = kind_queued(kind);
  assign is_nb   = kind_direct(kind);
  assign bad_amo = (kind == K_AMO) && spans_lines(req_addr, req_size);

  assign req_ready = !pend_v && !(is_q && sb_full);
  assign acc       = req_valid && req_ready;
  assign req_wdata = (kind == K_AMO || kind == K_CMO) ? '0 : req_data;

  // cache port selection
  assign sel_pend = pend_v && !nb_conflict;
  assign sel_byp  = !pend_v && sb_empty && req_valid && is_nb && !bad_amo;
  assign sel_head = !sel_pend && !sel_byp && !sb_empty;
  assign c_valid  = sel_pend || sel_byp || sel_head;
  assign pop      = sel_head && c_ready;
  assign push     = acc && is_q;

  always_comb begin
    if (sel_pend) begin
      c_kind = pend_kind;  c_tid = pend_tid;  c_addr = pend_addr;
      c_size = pend_size;  c_data = pend_data;
    end else if (sel_byp) begin
      c_kind = kind;       c_tid = req_tid;   c_addr = req_addr;
      c_size = req_size;   c_data = req_wdata;
    end else begin
      c_kind = age_cmo[0] ? K_CMO : K_STORE;
      c_tid  = age_tid[0]; c_addr = age_addr[0];
      c_size = age_size[0]; c_data = age_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
    end else if (sel_pend && c_ready) begin
      pend_v <= 1'b0;
    end else if (acc && is_nb && !bad_amo && !(sel_byp && c_ready)) begin
      pend_v <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (acc && is_nb && !pend_v) begin
      pend_kind <= kind;
      pend_tid  <= req_tid;
      pend_addr <= req_addr;
      pend_size <= req_size;
      pend_data <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      fwd_code  <= FWD_NONE;
      fwd_data  <= '0;
      amo_err   <= 1'b0;
    end else begin
      fwd_valid <= acc && is_ld;
      amo_err   <= acc && bad_amo;
      if (acc && is_ld) begin
        fwd_code <= scan_code;
        fwd_data <= scan_data;
      end
    end
  end

  stbuf_ring #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW), .SW(SW)) u_ring (
    .clk(clk), .rst(rst),
    .push(push), .push_addr(req_addr), .push_size(req_size),
    .push_data(req_wdata), .push_tid(req_tid), .push_cmo(kind == K_CMO),
    .pop(pop), .full(sb_full), .empty(sb_empty),
    .age_vld(age_vld), .age_addr(age_addr), .age_size(age_size),
    .age_data(age_data), .age_tid(age_tid), .age_cmo(age_cmo)
  );

  stbuf_scan #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW), .SW(SW)) u_scan (
    .age_vld(age_vld), .age_addr(age_addr), .age_size(age_size),
    .age_data(age_data), .age_tid(age_tid), .age_cmo(age_cmo),
    .ld_tid(req_tid), .ld_addr(req_addr), .ld_size(req_size),
    .nb_addr(pend_addr), .nb_size(pend_size),
    .fwd_code(scan_code), .fwd_data(scan_data), .nb_conflict(nb_conflict)
  );

  p_nb_not_queued_r1: assert property (@(posedge clk) disable iff (rst)
    (acc && is_nb && sb_empty) |=> sb_empty) else $error("direct request queued");

  p_nb_waits_r2: assert property (@(posedge clk) disable iff (rst)
    (c_valid && kind_direct(req_kind_e'(c_kind)) && !sb_empty) |-> !nb_conflict)
    else $error("direct request issued over overlapping entry");

  p_amo_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (c_valid && c_kind == K_AMO) |-> (c_data == '0)) else $error("atomic carries data");

  p_amo_in_line_r5: assert property (@(posedge clk) disable iff (rst)
    (c_valid && c_kind == K_AMO) |-> !spans_lines(c_addr, c_size))
    else $error("line-crossing atomic issued");

  p_fwd_nodata_r9: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid && fwd_code != FWD_FULL) |-> (fwd_data == '0))
    else $error("data without full coverage");

endmodule

// File: tb/test_stbuf_top.sv
`timescale 1ns/1ps
module test_stbuf_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = 3'd0;
  logic [1:0]  req_tid = '0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_data = '0;
  logic        fwd_valid;
  logic [1:0]  fwd_code;
  logic [63:0] fwd_data;
  logic        amo_err, sb_empty, sb_full;
  logic        c_valid;
  logic        c_ready = 1'b0;
  logic [2:0]  c_kind;
  logic [1:0]  c_tid;
  logic [31:0] c_addr;
  logic [1:0]  c_size;
  logic [63:0] c_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [2:0]  lg_kind [64];
  logic [31:0] lg_addr [64];
  logic [63:0] lg_data [64];
  int lg_n = 0;

  always #2.5 clk = ~clk;

  stbuf_top i_stbuf_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_tid(req_tid), .req_addr(req_addr),
    .req_size(req_size), .req_data(req_data), .fwd_valid(fwd_valid),
    .fwd_code(fwd_code), .fwd_data(fwd_data), .amo_err(amo_err),
    .sb_empty(sb_empty), .sb_full(sb_full), .c_valid(c_valid),
    .c_ready(c_ready), .c_kind(c_kind), .c_tid(c_tid), .c_addr(c_addr),
    .c_size(c_size), .c_data(c_data)
  );

  always @(negedge clk) begin
    if (!rst && c_valid && c_ready && lg_n < 64) begin
      lg_kind[lg_n] = c_kind;
      lg_addr[lg_n] = c_addr;
      lg_data[lg_n] = c_data;
      lg_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [1:0] t, input logic [31:0] a,
                      input logic [1:0] s, input logic [63:0] d);
    req_kind = k; req_tid = t; req_addr = a; req_size = s; req_data = d;
    req_valid = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    c_ready = 1'b1;
    @(negedge clk);
    while (!sb_empty || c_valid) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic load_chk(input logic [1:0] t, input logic [31:0] a, input logic [1:0] s,
                          input logic [1:0] exp_code, input logic [63:0] exp_data, input string req);
    send(3'd0, t, a, s, 64'h0);
    @(negedge clk);
    chk(fwd_valid == 1'b1, req, {63'd0, fwd_valid}, 64'd1);
    chk(fwd_code == exp_code, req, {62'd0, fwd_code}, {62'd0, exp_code});
    chk(fwd_data == exp_data, req, fwd_data, exp_data);
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    req_kind = 3'd1;
    @(negedge clk);
    chk(sb_empty && !sb_full, "R12 empty", {62'd0, sb_full, sb_empty}, 64'd1);
    chk(!c_valid, "R12 idle", {63'd0, c_valid}, 64'd0);
    chk(!fwd_valid && !amo_err, "R12 flags", {62'd0, fwd_valid, amo_err}, 64'd0);
    chk(req_ready, "R12 ready", {63'd0, req_ready}, 64'd1);
    @(posedge clk); #1;
  endtask

  task automatic t_fifo();
    int base;
    base = lg_n;
    c_ready = 1'b0;
    for (int i = 0; i < 4; i++) send(3'd1, 2'd0, 32'h40 + 32'(i * 8), 2'd3, 64'(i + 1));
    @(negedge clk);
    chk(sb_full, "R10 full", {63'd0, sb_full}, 64'd1);
    req_kind = 3'd1; req_addr = 32'h80; req_valid = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R10 store refused when full", {63'd0, req_ready}, 64'd0);
    @(posedge clk); #1 req_valid = 1'b0;
    c_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!sb_empty, "R10 one per cycle", {63'd0, sb_empty}, 64'd0);
    @(posedge clk); @(negedge clk);
    chk(sb_empty, "R10 drained in DEPTH cycles", {63'd0, sb_empty}, 64'd1);
    chk(lg_n == base + 4, "R10 count", 64'(lg_n - base), 64'd4);
    for (int i = 0; i < 4; i++)
      chk(lg_addr[base + i] == 32'h40 + 32'(i * 8), "R10 order", {32'd0, lg_addr[base + i]}, 64'(32'h40 + i * 8));
    @(posedge clk); #1;
  endtask

  task automatic t_forward();
    int base;
    c_ready = 1'b0;
    send(3'd1, 2'd0, 32'h100, 2'd3, 64'h1122334455667788);
    send(3'd1, 2'd0, 32'h104, 2'd2, 64'h00000000AABBCCDD);
    send(3'd1, 2'd1, 32'h100, 2'd3, 64'hF0E0D0C0B0A09080);
    send(3'd2, 2'd0, 32'h100, 2'd3, 64'h0);
    load_chk(2'd0, 32'h104, 2'd2, 2'd1, 64'hAABBCCDD, "R6 youngest full");
    load_chk(2'd0, 32'h100, 2'd1, 2'd1, 64'h7788, "R7 R8 skip thread and cmo");
    load_chk(2'd0, 32'h102, 2'd2, 2'd2, 64'h0, "R9 partial");
    load_chk(2'd0, 32'h200, 2'd3, 2'd0, 64'h0, "R9 none");
    load_chk(2'd1, 32'h106, 2'd0, 2'd1, 64'hE0, "R7 other thread byte");
    load_chk(2'd2, 32'h100, 2'd3, 2'd0, 64'h0, "R7 no same-thread entry");
    base = lg_n;
    drain();
    chk(lg_n == base + 4 && lg_kind[base + 3] == 3'd2, "R1 cmo queued", {61'd0, lg_kind[base + 3]}, 64'd2);
  endtask

  task automatic t_conflict();
    int base;
    base = lg_n;
    c_ready = 1'b0;
    send(3'd1, 2'd0, 32'h300, 2'd3, 64'h0102030405060708);
    send(3'd6, 2'd0, 32'h304, 2'd2, 64'hDEAD);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(c_valid && c_kind == 3'd1, "R2 store held first", {61'd0, c_kind}, 64'd1);
    @(posedge clk); #1;
    drain();
    chk(lg_n == base + 2, "R2 two issues", 64'(lg_n - base), 64'd2);
    chk(lg_kind[base] == 3'd1 && lg_addr[base] == 32'h300, "R2 store before atomic", {61'd0, lg_kind[base]}, 64'd1);
    chk(lg_kind[base + 1] == 3'd6, "R2 atomic after", {61'd0, lg_kind[base + 1]}, 64'd6);
    chk(lg_data[base + 1] == 64'h0, "R4 atomic data zero", lg_data[base + 1], 64'h0);
  endtask

  task automatic t_reorder();
    int base;
    base = lg_n;
    c_ready = 1'b0;
    send(3'd1, 2'd0, 32'h400, 2'd3, 64'hA);
    send(3'd1, 2'd0, 32'h408, 2'd3, 64'hB);
    send(3'd6, 2'd0, 32'h500, 2'd3, 64'h55);
    repeat (2) @(posedge clk); #1;
    drain();
    chk(lg_kind[base] == 3'd6 && lg_addr[base] == 32'h500, "R3 atomic overtakes", {32'd0, lg_addr[base]}, 64'h500);
    chk(lg_data[base] == 64'h0, "R4 atomic zeroed", lg_data[base], 64'h0);
    chk(lg_addr[base + 1] == 32'h400 && lg_addr[base + 2] == 32'h408, "R3 stores keep order",
        {lg_addr[base + 1], lg_addr[base + 2]}, {32'h400, 32'h408});
  endtask

  task automatic t_bypass();
    logic [2:0] kinds [3];
    kinds[0] = 3'd5; kinds[1] = 3'd3; kinds[2] = 3'd4;
    c_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      req_kind = kinds[i]; req_tid = 2'd0; req_addr = 32'h600 + 32'(i * 8);
      req_size = 2'd3; req_data = 64'h77; req_valid = 1'b1;
      @(negedge clk);
      chk(c_valid && c_kind == kinds[i] && c_addr == req_addr, "R11 same-cycle issue",
          {29'd0, c_kind, c_addr}, {29'd0, kinds[i], req_addr});
      @(posedge clk); #1 req_valid = 1'b0;
      @(negedge clk);
      chk(sb_empty && !c_valid, "R1 direct request not queued", {62'd0, sb_empty, c_valid}, 64'd2);
      @(posedge clk); #1;
    end
  endtask

  task automatic t_cross();
    int base;
    base = lg_n;
    c_ready = 1'b1;
    send(3'd6, 2'd0, 32'h73C, 2'd3, 64'h1);
    @(negedge clk);
    chk(amo_err, "R5 error pulse", {63'd0, amo_err}, 64'd1);
    chk(!c_valid, "R5 not issued", {63'd0, c_valid}, 64'd0);
    @(negedge clk);
    chk(!amo_err, "R5 pulse one cycle", {63'd0, amo_err}, 64'd0);
    chk(lg_n == base, "R5 nothing reached cache", 64'(lg_n - base), 64'd0);
    @(posedge clk); #1;
    send(3'd6, 2'd0, 32'h738, 2'd3, 64'h1);
    @(negedge clk);
    chk(!amo_err, "R5 in-line no error", {63'd0, amo_err}, 64'd0);
    chk(lg_n == base + 1, "R5 in-line issued", 64'(lg_n - base), 64'd1);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_fifo();
    t_forward();
    t_conflict();
    t_reorder();
    t_bypass();
    t_cross();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule